// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block produces the serial clock waveform for an I2C controller from the system clock. A prescaler divides the system clock into a slower module tick. Two programmable counts then set the length of the low and high parts of each serial clock period. Every phase also carries a fixed extra offset. That offset depends on the prescale value, or it is pinned to one value when the alternate variant is selected. The block drives an active-low pull enable for the clock line and a flag for the high phase. It also emits two single-cycle strobes that a bit-level engine uses to change data and to sample data.

Software loads the three counts through a small write port while the controller is held in module reset by `run_en` low. The counts take effect when `run_en` rises. Counts written while the clock runs are held in a shadow copy and are adopted at the next period boundary. START/STOP generation, shifting, clock stretching and arbitration belong to the neighbouring logic.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst_n` is low or `run_en` is low, `scl_drive_low`, `phase_high`, `tick_change` and `tick_sample` are all 0 (line released). When `run_en` falls during a period, the outputs are released from the next cycle on.
- R2: One module tick spans P+1 system cycles, where P is the prescale count. Every phase length scales by P+1.
- R3: The low phase lasts (L+d)*(P+1) system cycles. L is the low count and d is 7 for P=0, 6 for P=1 and 5 for P>=2.
- R4: The high phase lasts (H+d)*(P+1) system cycles, where H is the high count, and it follows each low phase directly.
- R5: When `fixed_offset` is 1, d is 6 whatever the value of P.
- R6: If the high count adopted at the start of a period is 0, the line stays released with no strobes until the next module reset. Writes made meanwhile do not restart it.
- R7: Counts written while `run_en` is low are applied on the first cycle after `run_en` is seen high. That cycle is the first cycle of a low phase.
- R8: A count written in the middle of a period leaves the running period unchanged and governs the next period.
- R9: A write accepted in the very cycle that closes a period is used by the period that starts next.
- R10: `tick_change` is high for exactly one cycle per period, on the first cycle of the low phase. It is never high together with `tick_sample`.
- R11: `tick_sample` is high for exactly one cycle per period, ((H+d)>>1)*(P+1) cycles after the first cycle of the high phase.
- R12: Write select encoding: `wr_sel`=0 prescale count, 1 low count, 2 high count. The data is taken when `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Module reset release; 0 holds the divider idle |
| fixed_offset | input | 1 | Variant select: 1 forces the phase offset to 6 |
| wr_en | input | 1 | Count write strobe |
| wr_sel | input | 2 | Count select (0 prescale, 1 low, 2 high) |
| wr_data | input | 16 | Count value |
| scl_drive_low | output | 1 | 1 while the clock line is pulled low |
| phase_high | output | 1 | 1 during the high phase |
| tick_change | output | 1 | Strobe on the first cycle of the low phase |
| tick_sample | output | 1 | Strobe at the middle of the high phase |

## Verification
A register write and a period boundary can fall in the same cycle. The write then competes with the adoption of the shadow counts into the running copy. The bench provokes this by counting cycles from the rise of `phase_high`. It presents a new low count on the last cycle of the high phase, so the write and the boundary meet at one clock edge. It then judges the length of the following low phase, which must already reflect the new count. A second case places a write in the middle of a low phase and expects the old length for that period and the new one for the next.

// File: rtl/scl_div_pkg.sv
// Package: shared phase encoding and the offset rule for the SCL divider.
// Assumes: counts are unsigned; the offset fits in 3 bits.
package scl_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    localparam logic [1:0] SEL_PSC  = 2'd0;
    localparam logic [1:0] SEL_LOW  = 2'd1;
    localparam logic [1:0] SEL_HIGH = 2'd2;

    // Extra module ticks added to each phase.
    function automatic logic [2:0] phase_offset(input logic psc_is_zero,
                                                input logic psc_is_one,
                                                input logic fixed_mode);
        if (fixed_mode)       return 3'd6;
        else if (psc_is_zero) return 3'd7;
        else if (psc_is_one)  return 3'd6;
        else                  return 3'd5;
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
// Module: scl_cfg_regs
// Holds the shadow counts written by software and the running copy used by
// the divider. The running copy is refreshed only on 'load'. A write in the
// same cycle as 'load' is forwarded into the running copy.
// Assumes: load is a single-cycle pulse from the phase sequencer.
module scl_cfg_regs
    import scl_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         fixed_in,
    input  logic         load,
    output logic         nxt_high_zero,
    output logic [W-1:0] act_psc,
    output logic [W-1:0] act_low,
    output logic [W-1:0] act_high,
    output logic         act_fixed
);

    logic [W-1:0] shd_psc, shd_low, shd_high;
    logic [W-1:0] nxt_psc, nxt_low, nxt_high;

    // Shadow counts follow software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_psc  <= '0;
            shd_low  <= '0;
            shd_high <= W'(1);
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PSC:  shd_psc  <= wr_data;
                SEL_LOW:  shd_low  <= wr_data;
                SEL_HIGH: shd_high <= wr_data;
                default:  ;
            endcase
        end
    end

    // Forward a same-cycle write into the values about to be adopted.
    always_comb begin
        nxt_psc  = (wr_en && wr_sel == SEL_PSC)  ? wr_data : shd_psc;
        nxt_low  = (wr_en && wr_sel == SEL_LOW)  ? wr_data : shd_low;
        nxt_high = (wr_en && wr_sel == SEL_HIGH) ? wr_data : shd_high;
    end

    assign nxt_high_zero = (nxt_high == '0);

    // Running copy is refreshed at a period boundary or on leaving reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_psc   <= '0;
            act_low   <= '0;
            act_high  <= W'(1);
            act_fixed <= 1'b0;
        end else if (load) begin
            act_psc   <= nxt_psc;
            act_low   <= nxt_low;
            act_high  <= nxt_high;
            act_fixed <= fixed_in;
        end
    end

endmodule

// File: rtl/scl_prescaler.sv
// Module: scl_prescaler
// Divides the system clock by (psc+1) and gives a one-cycle module tick.
// Assumes: 'clr' holds the count at zero while the divider is not running.
module scl_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] psc,
    output logic         mod_tick,
    output logic         pre_zero
);

    logic [W-1:0] pcnt;

    // Free-running prescale count, wrapped at the programmed limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   pcnt <= '0;
        else if (pcnt == psc) pcnt <= '0;
        else                  pcnt <= pcnt + W'(1);
    end

    assign mod_tick = !clr && (pcnt == psc);
    assign pre_zero = (pcnt == '0);

endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Sequences low and high phases in module ticks and produces the line
// control and strobes. It requests a reload of the running counts at each
// boundary. A zero high count parks it in the hold state.
// Assumes: act_* are stable except on the cycle after 'load'.
module scl_phase_seq
    import scl_div_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         mod_tick,
    input  logic         pre_zero,
    input  logic         nxt_high_zero,
    input  logic [W-1:0] act_low,
    input  logic [W-1:0] act_high,
    input  logic [2:0]   offset,
    output logic         load,
    output logic         counting,
    output logic         scl_drive_low,
    output logic         phase_high,
    output logic         tick_change,
    output logic         tick_sample
);

    phase_e        state;
    logic [CW-1:0] phcnt;
    logic [CW-1:0] low_last, high_last, high_mid;
    logic          low_end, high_end;

    // Phase limits in module ticks, offset included.
    always_comb begin
        low_last  = CW'(act_low)  + CW'(offset) - CW'(1);
        high_last = CW'(act_high) + CW'(offset) - CW'(1);
        high_mid  = (CW'(act_high) + CW'(offset)) >> 1;
    end

    assign low_end  = (state == PH_LOW)  && mod_tick && (phcnt == low_last);
    assign high_end = (state == PH_HIGH) && mod_tick && (phcnt == high_last);
    assign load     = run_en && ((state == PH_IDLE) || high_end);

    // Phase state and tick count within the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            state <= PH_IDLE;
            phcnt <= '0;
        end else begin
            case (state)
                PH_IDLE: begin
                    state <= nxt_high_zero ? PH_HOLD : PH_LOW;
                    phcnt <= '0;
                end
                PH_LOW: begin
                    if (low_end) begin
                        state <= PH_HIGH;
                        phcnt <= '0;
                    end else if (mod_tick) begin
                        phcnt <= phcnt + CW'(1);
                    end
                end
                PH_HIGH: begin
                    if (high_end) begin
                        state <= nxt_high_zero ? PH_HOLD : PH_LOW;
                        phcnt <= '0;
                    end else if (mod_tick) begin
                        phcnt <= phcnt + CW'(1);
                    end
                end
                default: begin
                    state <= PH_HOLD;
                    phcnt <= '0;
                end
            endcase
        end
    end

    // Line control and strobes decoded from the sequencer state.
    always_comb begin
        counting      = (state == PH_LOW) || (state == PH_HIGH);
        scl_drive_low = (state == PH_LOW);
        phase_high    = (state == PH_HIGH);
        tick_change   = (state == PH_LOW)  && (phcnt == '0) && pre_zero;
        tick_sample   = (state == PH_HIGH) && (phcnt == high_mid) && pre_zero;
    end

endmodule

// File: rtl/scl_timing_gen.sv
// Module: scl_timing_gen (top)
// I2C serial clock divider: prescaler, count registers and phase sequencer.
// Assumes: counts are programmed with run_en low before first use; the
// line itself is open-drain and driven low only while scl_drive_low is 1.
module scl_timing_gen
    import scl_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         fixed_offset,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         scl_drive_low,
    output logic         phase_high,
    output logic         tick_change,
    output logic         tick_sample
);

    localparam int CW = W + 1;

    logic         load, counting, mod_tick, pre_zero, nxt_high_zero;
    logic [W-1:0] act_psc, act_low, act_high;
    logic         act_fixed;
    logic [2:0]   offset;

    // Offset chosen from the running prescale count and variant select.
    always_comb begin
        offset = phase_offset(act_psc == '0, act_psc == W'(1), act_fixed);
    end

    scl_cfg_regs #(.W(W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .fixed_in      (fixed_offset),
        .load          (load),
        .nxt_high_zero (nxt_high_zero),
        .act_psc       (act_psc),
        .act_low       (act_low),
        .act_high      (act_high),
        .act_fixed     (act_fixed)
    );

    scl_prescaler #(.W(W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!counting),
        .psc      (act_psc),
        .mod_tick (mod_tick),
        .pre_zero (pre_zero)
    );

    scl_phase_seq #(.W(W), .CW(CW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .mod_tick      (mod_tick),
        .pre_zero      (pre_zero),
        .nxt_high_zero (nxt_high_zero),
        .act_low       (act_low),
        .act_high      (act_high),
        .offset        (offset),
        .load          (load),
        .counting      (counting),
        .scl_drive_low (scl_drive_low),
        .phase_high    (phase_high),
        .tick_change   (tick_change),
        .tick_sample   (tick_sample)
    );

endmodule

// File: rtl/scl_timing_chk.sv
// Module: scl_timing_chk
// Port-level properties of the divider, bound to the top module.
module scl_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic scl_drive_low,
    input logic phase_high,
    input logic tick_change,
    input logic tick_sample
);

    // R1: a cleared run enable releases the line on the next cycle
    assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!scl_drive_low && !phase_high && !tick_change && !tick_sample));

    // R4: the high phase follows the low phase while running
    assert_low_then_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && run_en) |=> (scl_drive_low || phase_high));

    // R3: the line is never low and in the high phase together
    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_drive_low && phase_high));

    // R10: every entry into the low phase carries the change strobe
    assert_change_at_low_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> tick_change);

    // R10: the two strobes never coincide
    assert_ticks_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_change, tick_sample}));

    // R11: the sample strobe only occurs inside the high phase
    assert_sample_in_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |-> phase_high);

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .scl_drive_low (scl_drive_low),
    .phase_high    (phase_high),
    .tick_change   (tick_change),
    .tick_sample   (tick_sample)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        fixed_offset = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        scl_drive_low, phase_high, tick_change, tick_sample;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    scl_timing_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .fixed_offset  (fixed_offset),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .scl_drive_low (scl_drive_low),
        .phase_high    (phase_high),
        .tick_change   (tick_change),
        .tick_sample   (tick_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Called at a negedge; one-cycle write.
    task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Hold in module reset, program counts, release.
    task automatic program_and_start(input int p, input int l, input int h, input bit fx);
        run_en = 1'b0;
        @(negedge clk);
        write_reg(2'd0, 16'(p));
        write_reg(2'd1, 16'(l));
        write_reg(2'd2, 16'(h));
        fixed_offset = fx;
        run_en = 1'b1;
    endtask

    // Measure one period starting at the next tick_change.
    task automatic measure(input int exp_low, input int exp_high, input int exp_samp,
                           input string tag);
        int n = 0;
        int lowc = 0, highc = 0, samp_off = -1, samp_cnt = 0, chg_cnt = 0;
        while (!tick_change && n < 2000) begin @(negedge clk); n++; end
        check(scl_drive_low == 1'b1, {tag, " R10 change strobe on low start"}, int'(scl_drive_low), 1);
        while (scl_drive_low && lowc < 2000) begin
            if (tick_change) chg_cnt++;
            lowc++;
            @(negedge clk);
        end
        while (phase_high && highc < 2000) begin
            if (tick_sample) begin samp_cnt++; samp_off = highc; end
            highc++;
            @(negedge clk);
        end
        check(lowc == exp_low, {tag, " low length"}, lowc, exp_low);
        check(highc == exp_high, {tag, " high length"}, highc, exp_high);
        check(samp_cnt == 1 && samp_off == exp_samp, {tag, " R11 sample offset"}, samp_off, exp_samp);
        check(chg_cnt == 1, {tag, " R10 single change strobe"}, chg_cnt, 1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; run_en = 1'b1;
        repeat (3) @(negedge clk);
        check({scl_drive_low, phase_high, tick_change, tick_sample} == 4'b0,
              "R1 outputs released in reset",
              int'({scl_drive_low, phase_high, tick_change, tick_sample}), 0);
        run_en = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({scl_drive_low, phase_high} == 2'b0, "R1 released while run_en low",
              int'({scl_drive_low, phase_high}), 0);
    endtask

    task automatic test_psc0();
        program_and_start(0, 3, 2, 1'b0);
        measure(10, 9, 4, "R3 R4 R7 R12 psc0 d7");
        measure(10, 9, 4, "R2 psc0 second period");
    endtask

    task automatic test_psc1();
        program_and_start(1, 4, 3, 1'b0);
        measure(20, 18, 8, "R2 R3 psc1 d6");
    endtask

    task automatic test_psc3();
        program_and_start(3, 2, 1, 1'b0);
        measure(28, 24, 12, "R2 R3 psc3 d5");
    endtask

    task automatic test_fixed();
        program_and_start(0, 3, 2, 1'b1);
        measure(9, 8, 4, "R5 fixed offset psc0");
        program_and_start(2, 3, 2, 1'b1);
        measure(27, 24, 12, "R5 fixed offset psc2");
    endtask

    task automatic test_drop_run();
        program_and_start(0, 3, 2, 1'b0);
        while (!tick_change) @(negedge clk);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(!scl_drive_low && !phase_high, "R1 release after run_en falls",
              int'({scl_drive_low, phase_high}), 0);
    endtask

    task automatic test_hold();
        int seen = 0;
        program_and_start(0, 3, 0, 1'b0);
        repeat (100) begin
            @(negedge clk);
            if (scl_drive_low || phase_high || tick_change || tick_sample) seen++;
        end
        check(seen == 0, "R6 zero high count gives no toggling", seen, 0);
        write_reg(2'd2, 16'd2);
        repeat (50) begin
            @(negedge clk);
            if (scl_drive_low || phase_high || tick_change || tick_sample) seen++;
        end
        check(seen == 0, "R6 held until module reset", seen, 0);
    endtask

    task automatic test_mid_write();
        program_and_start(0, 3, 2, 1'b0);
        fork
            measure(10, 9, 4, "R8 running period keeps old low");
            begin
                repeat (3) @(negedge clk);
                write_reg(2'd1, 16'd6);
            end
        join
        measure(13, 9, 4, "R8 next period uses new low");
    endtask

    task automatic test_boundary_write();
        // Running with low=6, high=2, psc=0: high phase 9 cycles.
        fork
            measure(13, 9, 4, "R9 period before boundary write");
            begin
                while (!phase_high) @(negedge clk);
                repeat (8) @(negedge clk);
                write_reg(2'd1, 16'd1);
            end
        join
        measure(8, 9, 4, "R9 boundary write adopted");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_psc0();
        test_psc1();
        test_psc3();
        test_fixed();
        test_drop_run();
        test_hold();
        test_mid_write();
        test_boundary_write();
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule